// File: doc/BRIEF.md
# Scaler Coefficient Bank Loader

The loader fills the coefficient memory of a video scaler for one direction at a time. Given a source size, a destination size and a direction select, it picks one of ten filter sets for that direction. The choice depends on whether the image grows, keeps its size or shrinks, and, when it shrinks, on how far. The loader then streams the chosen set out of a read-only table into a coefficient RAM, one 16-bit word per clock.

The coefficient RAM is organised in rows of eight slots. The horizontal filter uses seven taps per row and the vertical filter uses five. Slots above the tap count are never written. A full load covers 64 rows, which is two rows per phase for 32 phases. For horizontal shrinks, the destination width is first doubled up to two times to account for decimation stages ahead of the filter. A division over several cycles then gives the ratio in sixteenths. A completion pulse marks each finished load, and a sticky per-direction pending flag tells the filter that fresh coefficients are in place.

Top module: `coef_bank_loader`

## Requirements
- R1: When the destination size is strictly greater than the source size, set code 0 (grow) is selected, in either direction.
- R2: In horizontal mode, when the destination is not larger, the destination width is doubled if twice its value is strictly below the source width. The test is then applied once more, so at most two doublings occur. Vertical mode never doubles.
- R3: When the (adjusted) destination equals the source, set code 1 (same size) is selected. The two directions reach different table entries because their direction bits differ.
- R4: Otherwise s = floor(adjusted_dst*16/src) is formed, any s below 8 is raised to 8, and set code s-6 (2..9) is selected.
- R5: The table address is 14 bits: bit 13 is the direction (0 horizontal, 1 vertical), bits 12:9 the set code, bits 8:3 the row and bits 2:0 the tap. The table answers one cycle after `rom_en`.
- R6: Writes go to RAM address {row[5:0], slot[2:0]} in ascending order, one per cycle. Rows run 0..63, with slots 0..6 in horizontal mode and slots 0..4 in vertical mode. No other slot is ever written. Each word written is the table word for the same row and tap.
- R7: The first write appears 3 clock edges after the accepting start edge for grow and same-size cases, and 7 edges after it for ratio cases. All 448 (horizontal) or 320 (vertical) writes follow back to back.
- R8: `done` is high for exactly the one cycle after the last write.
- R9: The pending flag of the loaded direction rises together with `done` and stays high until its clear input is sampled high. When a set and a clear meet at the same edge, the set wins.
- R10: A start that arrives from the accepting edge through the cycle of the last write is ignored. A start during the `done` cycle is accepted.
- R11: During and right after reset, `rom_en`, `ram_we`, `done`, `pend_h` and `pend_v` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a load (sampled while idle) |
| mode_vert | input | 1 | 0 horizontal, 1 vertical |
| src_dim | input | 12 | Source width or height |
| dst_dim | input | 12 | Destination width or height |
| clr_pend_h | input | 1 | Clear horizontal pending flag |
| clr_pend_v | input | 1 | Clear vertical pending flag |
| rom_en | output | 1 | Table read enable |
| rom_addr | output | 14 | Table read address |
| rom_data | input | 16 | Table read data, one cycle after enable |
| ram_we | output | 1 | Coefficient RAM write enable |
| ram_addr | output | 9 | Coefficient RAM address {row, slot} |
| ram_wdata | output | 16 | Coefficient RAM write data |
| done | output | 1 | One-cycle end-of-load pulse |
| pend_h | output | 1 | Horizontal coefficients pending |
| pend_v | output | 1 | Vertical coefficients pending |

## Verification
Every result is due a fixed number of edges after the accepting start edge. The first write comes 3 edges later for grow and same-size cases and 7 edges later when the divider runs. Write j then follows at that point plus j, and `done` and the pending flag come one edge after the final write. The reference model counts edges from the start edge and derives the expected write enable, address, data, pulse and flags for each count. The outputs are compared at every falling edge, half a period after the rising edge that updates them. Stray starts and held clears are injected at known edge numbers, so the model can state exactly when they must change nothing.

// File: rtl/coef_loader_pkg.sv
package coef_loader_pkg;
  // set codes within one direction
  localparam int SET_UP         = 0;
  localparam int SET_UNITY      = 1;
  localparam int SET_RATIO_BASE = 2;

  typedef enum logic [1:0] {
    SEL_IDLE  = 2'd0,
    SEL_CLASS = 2'd1,
    SEL_DIV   = 2'd2
  } sel_st_e;
endpackage

// File: rtl/cl_set_select.sv
module cl_set_select
  import coef_loader_pkg::*;
#(
  parameter int DIM_W = 12,
  parameter int QB    = 4,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic             mode_in,
  input  logic [DIM_W-1:0] src_in,
  input  logic [DIM_W-1:0] dst_in,
  output logic             busy,
  output logic             idx_vld,
  output logic             idx_mode,
  output logic [IDX_W-1:0] idx
);
  localparam int RATIO_MIN = 1 << (QB - 1);
  localparam int CNT_W     = (QB > 1) ? $clog2(QB) : 1;
  localparam logic [IDX_W-1:0] IDX_MAX = IDX_W'(SET_RATIO_BASE + RATIO_MIN - 1);
  localparam logic [IDX_W-1:0] IDX_OFS = IDX_W'(RATIO_MIN - SET_RATIO_BASE);

  sel_st_e          st_q, st_n;
  logic [DIM_W-1:0] src_q, src_n, dst_q, dst_n, rem_q, rem_n;
  logic             mode_q, mode_n, vld_q, vld_n;
  logic [QB-1:0]    quo_q, quo_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic [IDX_W-1:0] idx_q, idx_n;

  // decimation-adjusted destination
  logic [DIM_W:0]   dbl_a, dbl_b, trial, src_x;
  logic [DIM_W-1:0] adj_1, adj_2, adj;
  logic             ge;
  logic [QB-1:0]    quo_nx, quo_cl;

  always_comb begin
    src_x  = {1'b0, src_q};
    dbl_a  = {dst_q, 1'b0};
    adj_1  = (dbl_a < src_x) ? dbl_a[DIM_W-1:0] : dst_q;
    dbl_b  = {adj_1, 1'b0};
    adj_2  = (dbl_b < src_x) ? dbl_b[DIM_W-1:0] : adj_1;
    adj    = mode_q ? dst_q : adj_2;
    trial  = {rem_q, 1'b0};
    ge     = (trial >= src_x);
    quo_nx = {quo_q[QB-2:0], ge};
    quo_cl = (quo_nx < QB'(RATIO_MIN)) ? QB'(RATIO_MIN) : quo_nx;
  end

  always_comb begin
    st_n   = st_q;
    src_n  = src_q;
    dst_n  = dst_q;
    mode_n = mode_q;
    rem_n  = rem_q;
    quo_n  = quo_q;
    cnt_n  = cnt_q;
    idx_n  = idx_q;
    vld_n  = 1'b0;
    case (st_q)
      SEL_IDLE: begin
        if (go) begin
          src_n  = src_in;
          dst_n  = dst_in;
          mode_n = mode_in;
          st_n   = SEL_CLASS;
        end
      end
      SEL_CLASS: begin
        if (dst_q > src_q) begin
          idx_n = IDX_W'(SET_UP);
          vld_n = 1'b1;
          st_n  = SEL_IDLE;
        end else if (adj == src_q) begin
          idx_n = IDX_W'(SET_UNITY);
          vld_n = 1'b1;
          st_n  = SEL_IDLE;
        end else begin
          rem_n = adj;
          quo_n = '0;
          cnt_n = '0;
          st_n  = SEL_DIV;
        end
      end
      SEL_DIV: begin
        rem_n = ge ? DIM_W'(trial - src_x) : trial[DIM_W-1:0];
        quo_n = quo_nx;
        cnt_n = cnt_q + 1'b1;
        if (cnt_q == CNT_W'(QB - 1)) begin
          idx_n = IDX_W'(quo_cl) - IDX_OFS;
          vld_n = 1'b1;
          st_n  = SEL_IDLE;
        end
      end
      default: st_n = SEL_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SEL_IDLE;
      src_q  <= '0;
      dst_q  <= '0;
      mode_q <= 1'b0;
      rem_q  <= '0;
      quo_q  <= '0;
      cnt_q  <= '0;
      idx_q  <= '0;
      vld_q  <= 1'b0;
    end else begin
      st_q   <= st_n;
      src_q  <= src_n;
      dst_q  <= dst_n;
      mode_q <= mode_n;
      rem_q  <= rem_n;
      quo_q  <= quo_n;
      cnt_q  <= cnt_n;
      idx_q  <= idx_n;
      vld_q  <= vld_n;
    end
  end

  assign busy     = (st_q != SEL_IDLE) || vld_q;
  assign idx_vld  = vld_q;
  assign idx_mode = mode_q;
  assign idx      = idx_q;

  // R4
  idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idx_vld |-> (idx <= IDX_MAX));

  // R1
  up_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SEL_CLASS && dst_q > src_q) |=> (idx_vld && idx == IDX_W'(SET_UP)));

  // R7
  div_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SEL_DIV && cnt_q == CNT_W'(QB - 1)) |=> idx_vld);
endmodule

// File: rtl/cl_copy_seq.sv
module cl_copy_seq #(
  parameter int IDX_W  = 4,
  parameter int ROWS   = 64,
  parameter int SLOTS  = 8,
  parameter int HTAPS  = 7,
  parameter int VTAPS  = 5,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic              mode_in,
  input  logic [IDX_W-1:0]  idx_in,
  output logic              rom_en,
  output logic [IDX_W+$clog2(ROWS)+$clog2(SLOTS):0] rom_addr,
  input  logic [DATA_W-1:0] rom_data,
  output logic              ram_we,
  output logic [$clog2(ROWS)+$clog2(SLOTS)-1:0] ram_addr,
  output logic [DATA_W-1:0] ram_wdata,
  output logic              fin,
  output logic              done,
  output logic              done_vert,
  output logic              busy
);
  localparam int ROW_W  = $clog2(ROWS);
  localparam int SLOT_W = $clog2(SLOTS);
  localparam int SET_W  = IDX_W + 1;
  localparam logic [SLOT_W-1:0] H_LAST = SLOT_W'(HTAPS - 1);
  localparam logic [SLOT_W-1:0] V_LAST = SLOT_W'(VTAPS - 1);
  localparam logic [ROW_W-1:0]  R_LAST = ROW_W'(ROWS - 1);

  logic              act_q, act_n, we_q, we_n, done_q, done_n, mode_q, mode_n;
  logic [SET_W-1:0]  set_q, set_n;
  logic [ROW_W-1:0]  row_q, row_n;
  logic [SLOT_W-1:0] tap_q, tap_n, tap_last;
  logic [ROW_W+SLOT_W-1:0] wa_q, wa_n;

  always_comb begin
    tap_last = mode_q ? V_LAST : H_LAST;
    act_n  = act_q;
    set_n  = set_q;
    mode_n = mode_q;
    row_n  = row_q;
    tap_n  = tap_q;
    if (go && !act_q) begin
      act_n  = 1'b1;
      set_n  = {mode_in, idx_in};
      mode_n = mode_in;
      row_n  = '0;
      tap_n  = '0;
    end else if (act_q) begin
      if (tap_q == tap_last) begin
        tap_n = '0;
        if (row_q == R_LAST) act_n = 1'b0;
        else                 row_n = row_q + 1'b1;
      end else begin
        tap_n = tap_q + 1'b1;
      end
    end
    we_n   = act_q;
    wa_n   = act_q ? {row_q, tap_q} : wa_q;
    done_n = fin;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      set_q  <= '0;
      mode_q <= 1'b0;
      row_q  <= '0;
      tap_q  <= '0;
      we_q   <= 1'b0;
      wa_q   <= '0;
      done_q <= 1'b0;
    end else begin
      act_q  <= act_n;
      set_q  <= set_n;
      mode_q <= mode_n;
      row_q  <= row_n;
      tap_q  <= tap_n;
      we_q   <= we_n;
      wa_q   <= wa_n;
      done_q <= done_n;
    end
  end

  assign fin       = we_q && !act_q;
  assign rom_en    = act_q;
  assign rom_addr  = {set_q, row_q, tap_q};
  assign ram_we    = we_q;
  assign ram_addr  = wa_q;
  assign ram_wdata = rom_data;
  assign done      = done_q;
  assign done_vert = mode_q;
  assign busy      = act_q || we_q;

  // R6
  slot_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> (ram_addr[SLOT_W-1:0] <= (mode_q ? V_LAST : H_LAST)));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8
  done_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> (!ram_we && $past(ram_we)));

  // R10
  go_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> (!act_q && !we_q));
endmodule

// File: rtl/coef_bank_loader.sv
module coef_bank_loader #(
  parameter int DIM_W  = 12,
  parameter int PHASES = 32,
  parameter int SLOTS  = 8,
  parameter int HTAPS  = 7,
  parameter int VTAPS  = 5,
  parameter int DATA_W = 16,
  parameter int QB     = 4,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              mode_vert,
  input  logic [DIM_W-1:0]  src_dim,
  input  logic [DIM_W-1:0]  dst_dim,
  input  logic              clr_pend_h,
  input  logic              clr_pend_v,
  output logic              rom_en,
  output logic [IDX_W+$clog2(2*PHASES)+$clog2(SLOTS):0] rom_addr,
  input  logic [DATA_W-1:0] rom_data,
  output logic              ram_we,
  output logic [$clog2(2*PHASES)+$clog2(SLOTS)-1:0] ram_addr,
  output logic [DATA_W-1:0] ram_wdata,
  output logic              done,
  output logic              pend_h,
  output logic              pend_v
);
  localparam int ROWS = 2 * PHASES;

  logic [1:0] rs_q;
  logic       rst_int;
  logic       go, sel_busy, cp_busy, idx_vld, idx_mode, fin, done_vert;
  logic [IDX_W-1:0] idx;
  logic       ph_q, ph_n, pv_q, pv_n;

  // reset asserted at once, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_int = rs_q[1];

  assign go = start && !sel_busy && !cp_busy;

  cl_set_select #(.DIM_W(DIM_W), .QB(QB), .IDX_W(IDX_W)) u_sel (
    .clk      (clk),
    .rst_n    (rst_int),
    .go       (go),
    .mode_in  (mode_vert),
    .src_in   (src_dim),
    .dst_in   (dst_dim),
    .busy     (sel_busy),
    .idx_vld  (idx_vld),
    .idx_mode (idx_mode),
    .idx      (idx)
  );

  cl_copy_seq #(.IDX_W(IDX_W), .ROWS(ROWS), .SLOTS(SLOTS), .HTAPS(HTAPS),
                .VTAPS(VTAPS), .DATA_W(DATA_W)) u_copy (
    .clk       (clk),
    .rst_n     (rst_int),
    .go        (idx_vld),
    .mode_in   (idx_mode),
    .idx_in    (idx),
    .rom_en    (rom_en),
    .rom_addr  (rom_addr),
    .rom_data  (rom_data),
    .ram_we    (ram_we),
    .ram_addr  (ram_addr),
    .ram_wdata (ram_wdata),
    .fin       (fin),
    .done      (done),
    .done_vert (done_vert),
    .busy      (cp_busy)
  );

  // pending flags: set on the last write, set wins over clear
  always_comb begin
    ph_n = ph_q;
    pv_n = pv_q;
    if (fin && !done_vert)  ph_n = 1'b1;
    else if (clr_pend_h)    ph_n = 1'b0;
    if (fin && done_vert)   pv_n = 1'b1;
    else if (clr_pend_v)    pv_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_int) begin
    if (!rst_int) begin
      ph_q <= 1'b0;
      pv_q <= 1'b0;
    end else begin
      ph_q <= ph_n;
      pv_q <= pv_n;
    end
  end

  assign pend_h = ph_q;
  assign pend_v = pv_q;

  // R9
  pend_set_chk: assert property (@(posedge clk) disable iff (!rst_int)
    done |-> (done_vert ? pend_v : pend_h));

  // R9
  pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_int)
    (pend_h && !clr_pend_h) |=> pend_h);

  // R11
  quiet_reset_chk: assert property (@(posedge clk)
    !rst_int |-> (!ram_we && !done && !rom_en));
endmodule

// File: tb/sim_coef_bank_loader.sv
module sim_coef_bank_loader;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, mode_vert = 1'b0;
  logic [11:0] src_dim = '0, dst_dim = '0;
  logic        clr_pend_h = 1'b0, clr_pend_v = 1'b0;
  logic        rom_en, ram_we, done, pend_h, pend_v;
  logic [13:0] rom_addr;
  logic [15:0] rom_data = '0;
  logic [8:0]  ram_addr;
  logic [15:0] ram_wdata;

  int n_run = 0, n_fail = 0;
  bit mp_h = 0, mp_v = 0;

  always #2 clk = ~clk;

  // table model: data word tags its own address
  always @(posedge clk) if (rom_en) rom_data <= {2'b01, rom_addr};

  coef_bank_loader u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .mode_vert(mode_vert),
    .src_dim(src_dim), .dst_dim(dst_dim), .clr_pend_h(clr_pend_h),
    .clr_pend_v(clr_pend_v), .rom_en(rom_en), .rom_addr(rom_addr),
    .rom_data(rom_data), .ram_we(ram_we), .ram_addr(ram_addr),
    .ram_wdata(ram_wdata), .done(done), .pend_h(pend_h), .pend_v(pend_v));

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp, int e);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s edge=%0d actual=%h expected=%h", tag, e, got, exp);
    end
  endtask

  // R1 R2 R3 R4 reference selection
  function automatic int ref_set(bit v, int s, int d, output int lat);
    int a, q;
    lat = 2;
    if (d > s) return 0;
    a = d;
    if (!v) begin
      if (2 * a < s) a = 2 * a;
      if (2 * a < s) a = 2 * a;
    end
    if (a == s) return 1;
    lat = 6;
    q = (a * 16) / s;
    if (q < 8) q = 8;
    return q - 6;
  endfunction

  task automatic run_load(string tag, bit v, int s, int d, bit ch, bit cv, int rk);
    int lat, idx, taps, n, last;
    idx  = ref_set(v, s, d, lat);
    taps = v ? 5 : 7;
    n    = 64 * taps;
    last = lat + n + 2;
    @(negedge clk);
    start = 1'b1; mode_vert = v; src_dim = 12'(s); dst_dim = 12'(d);
    clr_pend_h = ch; clr_pend_v = cv;
    for (int e = 0; e <= last; e++) begin
      @(negedge clk);
      if (e == lat + n + 1) begin
        if (v) mp_v = 1; else mp_h = 1;
        if (ch && v) mp_h = 0;
        if (cv && !v) mp_v = 0;
      end else begin
        if (ch) mp_h = 0;
        if (cv) mp_v = 0;
      end
      begin
        bit xw;
        xw = (e >= lat + 1) && (e <= lat + n);
        // R7 write timing, R8 done pulse, R9 flags
        chk({tag, " R7 R8 R9 ctrl"}, {28'd0, ram_we, done, pend_h, pend_v},
            {28'd0, xw, (e == lat + n + 1), mp_h, mp_v}, e);
        if (xw) begin
          int j, r, t;
          j = e - lat - 1; r = j / taps; t = j % taps;
          // R5 R6 address and data
          chk({tag, " R5 R6 data"}, {7'd0, ram_addr, ram_wdata},
              {7'd0, 6'(r), 3'(t), 2'b01, v, 4'(idx), 6'(r), 3'(t)}, e);
        end
      end
      // R10 stray start with other operands
      if (e + 1 == rk) begin
        start = 1'b1; mode_vert = ~v; src_dim = 12'd8; dst_dim = 12'd16;
      end else begin
        start = 1'b0;
      end
    end
    clr_pend_h = 1'b0; clr_pend_v = 1'b0;
  endtask

  task automatic pulse_clear(bit ch, bit cv);
    @(negedge clk);
    clr_pend_h = ch; clr_pend_v = cv;
    @(negedge clk);
    if (ch) mp_h = 0;
    if (cv) mp_v = 0;
    clr_pend_h = 1'b0; clr_pend_v = 1'b0;
    // R9 clear
    chk("R9 clear", {30'd0, pend_h, pend_v}, {30'd0, mp_h, mp_v}, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog R7 actual=hung expected=finished");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11
    chk("R11 in reset", {28'd0, rom_en, ram_we, done, pend_h | pend_v}, 32'd0, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R11 after reset", {28'd0, rom_en, ram_we, done, pend_h | pend_v}, 32'd0, 0);

    run_load("R1 h grow",        0, 100, 200, 0, 0, 0);
    run_load("R1 v grow",        1, 480, 720, 0, 0, 0);
    run_load("R3 h same",        0, 640, 640, 0, 0, 0);
    pulse_clear(1, 0);
    run_load("R3 v same",        1, 480, 480, 0, 0, 0);
    run_load("R4 h 10/16",       0, 1920, 1280, 0, 0, 0);
    run_load("R2 h two doubles", 0, 1920, 400, 0, 0, 0);
    run_load("R2 R4 h clamp",    0, 1000, 100, 0, 0, 0);
    run_load("R4 v clamp",       1, 1080, 100, 0, 0, 0);
    run_load("R4 v 15/16",       1, 1080, 1079, 0, 0, 0);
    run_load("R2 h one double",  0, 300, 100, 0, 0, 0);
    run_load("R10 start in div", 0, 1920, 1280, 0, 0, 4);
    run_load("R10 start in copy", 1, 720, 500, 0, 0, 100);
    run_load("R10 start last write", 1, 720, 720, 0, 0, 2 + 320);
    pulse_clear(0, 1);
    pulse_clear(1, 0);
    run_load("R9 set beats clear", 0, 800, 600, 1, 0, 0);
    run_load("R9 other flag clears", 1, 600, 300, 1, 0, 0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule